// File: doc/BRIEF.md
# Timed or Strobed Word Capture Controller

This block samples a 32-bit parallel input bus, built from four byte lanes, and hands each sampled word to a downstream consumer over a valid/ready stream. A capture is requested either by an internal period generator that counts ticks of a fixed time base or by an external strobe pin. The strobe pin is synchronised, and either its rising edge or its falling edge is used.

Configuration arrives as plain input fields. An operation-mode byte holds a three-bit run field, where only the value 7 enables capture, and a counted-mode flag in bit 3. The other fields are a line-polarity byte, a period in ticks, a word count and a lane-enable mask.

In counted mode the block halts after the programmed number of delivered words and emits a one-cycle expiry pulse. A later word is captured only after the run field leaves 7 and comes back. Without counted mode, capture runs until the run field is cleared. When the consumer still holds an unaccepted word at the moment of a new capture, the new word is dropped and a wait-error pulse is raised. The block sends a one-cycle acknowledge for every word it accepts.

Top module: `word_capture_ctrl`

## Requirements
- R1: After synchronous reset, out_valid, ack, wait_err and count_expired are all low.
- R2: Capture happens only while op_mode[2:0] equals 7. Any other run value produces no words, and writing 0 to the field stops a running capture.
- R3: With src_ext low, the internal generator requests a capture every max(period_ticks,1) x TICK_DIV clock cycles, where one tick is TICK_DIV clocks. A period of 0 behaves as a period of 1.
- R4: With src_ext high and line_pol[1] clear, each rising edge of ext_req causes exactly one capture, after a two-flop synchroniser.
- R5: With src_ext high and line_pol[1] set, each falling edge of ext_req causes exactly one capture, and rising edges cause none.
- R6: With src_ext high the internal generator causes no capture. With src_ext low, edges on ext_req cause no capture.
- R7: Byte lane i of data_in (lane A = bits 7:0, lane D = bits 31:24) appears at the same position in out_data when lane_en[i] is 1 and reads as zero when lane_en[i] is 0.
- R8: With op_mode[3] set, capture halts after max(xfer_count,1) accepted words. count_expired pulses for one cycle together with the ack of the last word. Capture resumes only after the run field leaves 7 and returns to it.
- R9: With op_mode[3] clear, capture continues for as long as the run field stays 7, with no limit on the word count.
- R10: While out_valid is high and out_ready is low, out_data does not change. A capture in that state is dropped, raises wait_err for one cycle and is not counted.
- R11: ack pulses for one cycle for each accepted word, in the cycle in which that word first shows on out_data with out_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 8 | Bits 2:0 run field (7 = run), bit 3 counted mode |
| src_ext | input | 1 | 0 = internal period generator, 1 = external strobe |
| line_pol | input | 8 | Bit 1 selects the falling edge of the strobe |
| period_ticks | input | 32 | Capture period in ticks |
| xfer_count | input | 32 | Words to deliver in counted mode |
| lane_en | input | 4 | Per-byte lane enable |
| data_in | input | 32 | Parallel input word, lane A in the low byte |
| ext_req | input | 1 | External capture strobe (asynchronous) |
| out_data | output | 32 | Captured word |
| out_valid | output | 1 | Captured word is available |
| out_ready | input | 1 | Consumer accepts the word |
| ack | output | 1 | One-cycle pulse per accepted capture |
| wait_err | output | 1 | One-cycle pulse for a dropped capture |
| count_expired | output | 1 | One-cycle pulse when the counted transfer ends |

## Verification
The hardest case to reach from the ports is a capture that arrives while the output register still holds a word that has not been accepted. The stimulus holds out_ready low, fires two strobe edges with different input words, and then checks three things: the first word is still present, exactly one wait-error pulse was raised, and only one word comes out once ready is raised. Counted-mode expiry is reached with a short internal period. The halt is then shown to persist until the run field is cycled through a non-run value.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

    localparam logic [2:0] RUN_GO    = 3'd7;
    localparam int         NUM_BIT   = 3;
    localparam int         INV_BIT   = 1;

    typedef enum logic {
        SRC_TIMER  = 1'b0,
        SRC_STROBE = 1'b1
    } req_src_e;

    typedef struct packed {
        logic go;
        logic numbered;
    } opcfg_t;

    function automatic opcfg_t decode_op(input logic [7:0] op);
        opcfg_t c;
        c.go       = (op[2:0] == RUN_GO);
        c.numbered = op[NUM_BIT];
        return c;
    endfunction

    function automatic logic [31:0] at_least_one(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/wcap_tick_gen.sv
module wcap_tick_gen
    import wcap_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    output logic             req
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0]    presc;
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] lim;
    logic             tick;
    logic             wrap;

    assign lim  = CNT_W'(at_least_one(32'(period)));
    assign tick = (presc == PW'(TICK_DIV - 1));
    assign wrap = (pcnt >= lim - 1'b1);
    assign req  = en && tick && wrap;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            presc <= '0;
            pcnt  <= '0;
        end else begin
            presc <= tick ? '0 : presc + 1'b1;
            if (tick) pcnt <= wrap ? '0 : pcnt + 1'b1;
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_spacing
            AST_REQ_SPACED: assert property (@(posedge clk) disable iff (rst)
                req |=> !req); // R3
        end
    endgenerate

endmodule

// File: rtl/wcap_ext_edge.sv
module wcap_ext_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic falling,
    output logic hit
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], strobe};
    end

    assign hit = falling ? (sh[2] & ~sh[1]) : (sh[1] & ~sh[2]);

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit); // R4

endmodule

// File: rtl/wcap_out_stage.sv
module wcap_out_stage #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [WORD_W-1:0] word,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              accept,
    output logic              ack,
    output logic              wait_err
);
    logic full;

    assign full   = out_valid && !out_ready;
    assign accept = cap && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            ack       <= 1'b0;
            wait_err  <= 1'b0;
        end else begin
            ack      <= accept;
            wait_err <= cap && full;
            if (accept) begin
                out_data  <= word;
                out_valid <= 1'b1;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data)); // R10
    AST_ACK_VALID: assert property (@(posedge clk) disable iff (rst)
        ack |-> out_valid); // R11
    AST_ERR_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        wait_err |-> !ack); // R10

endmodule

// File: rtl/word_capture_ctrl.sv
module word_capture_ctrl
    import wcap_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int LANES    = 4,
    parameter int LANE_W   = 8,
    parameter int CNT_W    = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              op_mode,
    input  logic                    src_ext,
    input  logic [7:0]              line_pol,
    input  logic [CNT_W-1:0]        period_ticks,
    input  logic [CNT_W-1:0]        xfer_count,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] data_in,
    input  logic                    ext_req,
    output logic [LANES*LANE_W-1:0] out_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    ack,
    output logic                    wait_err,
    output logic                    count_expired
);
    localparam int WORD_W = LANES * LANE_W;

    opcfg_t           cfg;
    req_src_e         src;
    logic             halted;
    logic             active;
    logic             req_int;
    logic             req_ext;
    logic             cap;
    logic             accept;
    logic             expire_now;
    logic [CNT_W-1:0] wcnt;
    logic [CNT_W-1:0] lim;
    logic [WORD_W-1:0] word;

    assign cfg    = decode_op(op_mode);
    assign src    = req_src_e'(src_ext);
    assign active = cfg.go && !halted;
    assign lim    = CNT_W'(at_least_one(32'(xfer_count)));

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign word[g*LANE_W +: LANE_W] = lane_en[g] ? data_in[g*LANE_W +: LANE_W] : '0;
        end
    endgenerate

    wcap_tick_gen #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .en     (active && (src == SRC_TIMER)),
        .period (period_ticks),
        .req    (req_int)
    );

    wcap_ext_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .strobe  (ext_req),
        .falling (line_pol[INV_BIT]),
        .hit     (req_ext)
    );

    assign cap = active && ((src == SRC_STROBE) ? req_ext : req_int);

    wcap_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .cap       (cap),
        .word      (word),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .accept    (accept),
        .ack       (ack),
        .wait_err  (wait_err)
    );

    assign expire_now = accept && cfg.numbered && (wcnt + 1'b1 >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            halted        <= 1'b0;
            wcnt          <= '0;
            count_expired <= 1'b0;
        end else begin
            count_expired <= expire_now;
            if (!cfg.go)         halted <= 1'b0;
            else if (expire_now) halted <= 1'b1;
            if (!active)     wcnt <= '0;
            else if (accept) wcnt <= wcnt + 1'b1;
        end
    end

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op_mode[2:0] != RUN_GO) |=> !ack); // R2
    AST_EXPIRE_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        count_expired |-> ack); // R8
    AST_EXPIRE_HALTS: assert property (@(posedge clk) disable iff (rst)
        count_expired |=> !ack); // R8
    AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        count_expired |=> !count_expired); // R8

endmodule

// File: tb/test_word_capture_ctrl.sv
module test_word_capture_ctrl;
    localparam int TD = 4;

    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  op_mode = 0;
    logic        src_ext = 0;
    logic [7:0]  line_pol = 0;
    logic [31:0] period_ticks = 1;
    logic [31:0] xfer_count = 0;
    logic [3:0]  lane_en = 4'hF;
    logic [31:0] data_in = 0;
    logic        ext_req = 0;
    logic        out_ready = 1;
    logic [31:0] out_data;
    logic        out_valid, ack, wait_err, count_expired;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, n_words = 0, n_ack = 0, n_werr = 0, n_exp = 0;
    int t_last = 0, t_prev = 0;
    logic [31:0] last_word = 0;

    always #4 clk = ~clk;

    word_capture_ctrl #(.TICK_DIV(TD)) i_word_capture_ctrl (
        .clk(clk), .rst(rst), .op_mode(op_mode), .src_ext(src_ext),
        .line_pol(line_pol), .period_ticks(period_ticks), .xfer_count(xfer_count),
        .lane_en(lane_en), .data_in(data_in), .ext_req(ext_req),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .ack(ack), .wait_err(wait_err), .count_expired(count_expired)
    );

    always @(posedge clk) begin
        cyc++;
        if (!rst) begin
            if (out_valid && out_ready) begin
                n_words++;
                last_word = out_data;
                t_prev = t_last;
                t_last = cyc;
            end
            if (ack) n_ack++;
            if (wait_err) n_werr++;
            if (count_expired) n_exp++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_words = 0; n_ack = 0; n_werr = 0; n_exp = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ext();
        ext_req = 1; idle(6);
        ext_req = 0; idle(6);
    endtask

    task automatic stop_all();
        op_mode = 0; idle(4); out_ready = 1; idle(4); clear_counts();
    endtask

    task automatic t_reset();
        idle(1);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 ack", ack, 0);
        chk("R1 wait_err", wait_err, 0);
        chk("R1 count_expired", count_expired, 0);
    endtask

    task automatic t_timer();
        src_ext = 0; period_ticks = 3; data_in = 32'h1234_5678;
        op_mode = 8'h07; idle(100);
        chk("R3 interval", t_last - t_prev, 3 * TD);
        chk("R3 some words", n_words >= 5, 1);
        chk("R11 ack per word", n_ack, n_words);
        chk("R3 data", last_word, 32'h1234_5678);
        stop_all(); idle(40);
        chk("R2 stopped", n_words, 0);
        op_mode = 8'h03; idle(60);
        chk("R2 run field 3", n_words, 0);
        stop_all();
        period_ticks = 0; op_mode = 8'h07; idle(40);
        chk("R3 period zero", t_last - t_prev, TD);
        stop_all();
    endtask

    task automatic t_ext_rise();
        src_ext = 1; line_pol = 8'h00; data_in = 32'hA1B2_C3D4; lane_en = 4'hF;
        op_mode = 8'h07; idle(4);
        repeat (3) pulse_ext();
        chk("R4 rising edges", n_words, 3);
        chk("R7 full lanes", last_word, 32'hA1B2_C3D4);
        lane_en = 4'b0101; pulse_ext();
        chk("R7 masked lanes", last_word, 32'h00B2_00D4);
        lane_en = 4'hF;
        stop_all();
        src_ext = 0; period_ticks = 1000; op_mode = 8'h07;
        repeat (3) pulse_ext();
        chk("R6 strobe ignored in timer mode", n_words, 0);
        stop_all();
        src_ext = 1; period_ticks = 1; op_mode = 8'h07; idle(60);
        chk("R6 timer idle in strobe mode", n_words, 0);
        stop_all();
    endtask

    task automatic t_ext_fall();
        src_ext = 1; line_pol = 8'h02; op_mode = 8'h07; idle(4);
        ext_req = 1; idle(8);
        chk("R5 no capture on rise", n_words, 0);
        ext_req = 0; idle(8);
        chk("R5 capture on fall", n_words, 1);
        line_pol = 0;
        stop_all();
    endtask

    task automatic t_numbered();
        src_ext = 0; period_ticks = 1; xfer_count = 3;
        op_mode = 8'h0F; idle(200);
        chk("R8 count words", n_words, 3);
        chk("R8 expiry pulse", n_exp, 1);
        stop_all();
        xfer_count = 0; op_mode = 8'h0F; idle(100);
        chk("R8 restart count zero", n_words, 1);
        stop_all();
        op_mode = 8'h07; idle(200);
        chk("R9 continues", n_words > 10, 1);
        chk("R9 no expiry", n_exp, 0);
        stop_all();
    endtask

    task automatic t_backpressure();
        src_ext = 1; line_pol = 0; out_ready = 0; op_mode = 8'h07; idle(4);
        data_in = 32'h0000_AAAA; pulse_ext();
        data_in = 32'h0000_BBBB; pulse_ext();
        chk("R10 valid held", out_valid, 1);
        chk("R10 data held", out_data, 32'h0000_AAAA);
        chk("R10 wait error", n_werr, 1);
        chk("R11 one ack", n_ack, 1);
        out_ready = 1; idle(4);
        chk("R10 one word out", n_words, 1);
        chk("R10 word kept", last_word, 32'h0000_AAAA);
        stop_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3); rst = 0;
        t_reset();
        t_timer();
        t_ext_rise();
        t_ext_fall();
        t_numbered();
        t_backpressure();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule